// File: doc/BRIEF.md
# Four-Input Max/Min Index Finder

The block takes four unsigned operands presented together and reports, from one evaluation, both the largest and the smallest of them. For each extreme it returns the operand's value unchanged and its position. Ties always resolve to the lowest position. Selection is made by two balanced trees of pairwise comparators. One tree keeps the greater side and the other keeps the smaller side.

The result can leave the block combinationally or through one register stage, chosen by a parameter. In the registered build, a result is captured on a clock edge where `valid_i` is high, and `valid_o` marks it one clock later. When `valid_i` is low, the captured result holds.

All operands arrive on one flat bus. Operand k occupies bits `[k*DATA_W +: DATA_W]`.

Top module: `quad_extreme_finder`

## Requirements
- R1: `max_val_o` equals the largest operand under unsigned comparison, where operand k is `opd_i[k*DATA_W +: DATA_W]`.
- R2: `max_idx_o` is the position k (binary, 0 to 3) of the operand that is reported as the maximum. When several operands share the maximum, it is the lowest such k.
- R3: `min_val_o` equals the smallest operand under unsigned comparison.
- R4: `min_idx_o` is the position of the operand reported as the minimum. When several operands share the minimum, it is the lowest such k.
- R5: When all four operands are equal, `max_idx_o` and `min_idx_o` are both 0, and both value outputs equal the common operand.
- R6: With `REG_OUT=1`, consider a rising edge where `valid_i` is high. After that edge, all four result outputs show the result for the operands sampled at the edge, and `valid_o` is 1.
- R7: With `REG_OUT=1`, consider a rising edge where `valid_i` is low. After that edge, `valid_o` is 0 and all four result outputs keep their previous values, whatever the operands were.
- R8: With `REG_OUT=1`, while `rst_ni` is low, `valid_o` and all four result outputs are 0.
- R9: With `REG_OUT=0`, the results follow the operands within the same cycle, and `valid_o` equals `valid_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operands on `opd_i` are valid |
| opd_i | input | N_IN*DATA_W | Packed operands, operand k at bits `[k*DATA_W +: DATA_W]` |
| max_val_o | output | DATA_W | Value of the largest operand |
| max_idx_o | output | $clog2(N_IN) | Position of the largest operand |
| min_val_o | output | DATA_W | Value of the smallest operand |
| min_idx_o | output | $clog2(N_IN) | Position of the smallest operand |
| valid_o | output | 1 | Results are valid |

## Verification
The bench drives one registered and one combinational instance from the same stimulus. Each new operand set is applied just after a falling edge.

The combinational results are due within that same half cycle, so they are sampled 1 ns after the drive. The registered results are due after the following rising edge, so they are sampled at the next falling edge, where `valid_o` and all four fields must have changed together.

For hold cycles, new operands are driven with `valid_i` low. The registered outputs are then compared one edge later against the previous expected result.

// File: rtl/quad_xf_pkg.sv
package quad_xf_pkg;
  typedef enum logic {SEL_MAX = 1'b0, SEL_MIN = 1'b1} sel_mode_e;
endpackage

// File: rtl/xf_node.sv
module xf_node
  import quad_xf_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 2,
  parameter sel_mode_e   MODE   = SEL_MAX
) (
  input  logic [DATA_W-1:0] a_val_i,
  input  logic [IDX_W-1:0]  a_idx_i,
  input  logic [DATA_W-1:0] b_val_i,
  input  logic [IDX_W-1:0]  b_idx_i,
  output logic [DATA_W-1:0] w_val_o,
  output logic [IDX_W-1:0]  w_idx_o
);
  logic take_b;

  // lower-indexed side (a) keeps ties; b needs a strict win
  generate
    if (MODE == SEL_MAX) begin : g_max
      assign take_b = b_val_i > a_val_i;
    end else begin : g_min
      assign take_b = b_val_i < a_val_i;
    end
  endgenerate

  assign w_val_o = take_b ? b_val_i : a_val_i;
  assign w_idx_o = take_b ? b_idx_i : a_idx_i;
endmodule

// File: rtl/xf_tree.sv
module xf_tree
  import quad_xf_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N_IN   = 4,
  parameter sel_mode_e   MODE   = SEL_MAX,
  localparam int unsigned IDX_W  = $clog2(N_IN),
  localparam int unsigned LEVELS = $clog2(N_IN)
) (
  input  logic [N_IN*DATA_W-1:0] opd_i,
  output logic [DATA_W-1:0]      val_o,
  output logic [IDX_W-1:0]       idx_o
);
  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int unsigned CNT = N_IN >> l;
    logic [DATA_W-1:0] v [CNT];
    logic [IDX_W-1:0]  x [CNT];
    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < CNT; j++) begin : g_in
        assign v[j] = opd_i[j*DATA_W +: DATA_W];
        assign x[j] = IDX_W'(j);
      end
    end else begin : g_cmp
      for (genvar j = 0; j < CNT; j++) begin : g_node
        xf_node #(
          .DATA_W(DATA_W),
          .IDX_W (IDX_W),
          .MODE  (MODE)
        ) i_node (
          .a_val_i(g_lvl[l-1].v[2*j]),
          .a_idx_i(g_lvl[l-1].x[2*j]),
          .b_val_i(g_lvl[l-1].v[2*j+1]),
          .b_idx_i(g_lvl[l-1].x[2*j+1]),
          .w_val_o(v[j]),
          .w_idx_o(x[j])
        );
      end
    end
  end

  assign val_o = g_lvl[LEVELS].v[0];
  assign idx_o = g_lvl[LEVELS].x[0];
endmodule

// File: rtl/xf_out_stage.sv
module xf_out_stage #(
  parameter int unsigned PAY_W   = 20,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [PAY_W-1:0] pay_i,
  output logic             valid_o,
  output logic [PAY_W-1:0] pay_o
);
  generate
    if (REG_OUT) begin : g_reg
      logic             valid_q;
      logic [PAY_W-1:0] pay_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          valid_q <= 1'b0;
          pay_q   <= '0;
        end else begin
          valid_q <= valid_i;
          if (valid_i) pay_q <= pay_i;
        end
      end
      assign valid_o = valid_q;
      assign pay_o   = pay_q;
    end else begin : g_comb
      assign valid_o = valid_i;
      assign pay_o   = pay_i;
    end
  endgenerate
endmodule

// File: rtl/quad_extreme_finder.sv
module quad_extreme_finder
  import quad_xf_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned N_IN    = 4,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned IDX_W  = $clog2(N_IN),
  localparam int unsigned PAY_W  = 2 * (DATA_W + IDX_W)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [N_IN*DATA_W-1:0] opd_i,
  output logic [DATA_W-1:0]      max_val_o,
  output logic [IDX_W-1:0]       max_idx_o,
  output logic [DATA_W-1:0]      min_val_o,
  output logic [IDX_W-1:0]       min_idx_o,
  output logic                   valid_o
);
  logic [DATA_W-1:0] hi_val, lo_val;
  logic [IDX_W-1:0]  hi_idx, lo_idx;
  logic [PAY_W-1:0]  pay_d, pay_q;

  xf_tree #(.DATA_W(DATA_W), .N_IN(N_IN), .MODE(SEL_MAX)) i_hi_tree (
    .opd_i(opd_i),
    .val_o(hi_val),
    .idx_o(hi_idx)
  );

  xf_tree #(.DATA_W(DATA_W), .N_IN(N_IN), .MODE(SEL_MIN)) i_lo_tree (
    .opd_i(opd_i),
    .val_o(lo_val),
    .idx_o(lo_idx)
  );

  assign pay_d = {hi_val, hi_idx, lo_val, lo_idx};

  xf_out_stage #(.PAY_W(PAY_W), .REG_OUT(REG_OUT)) i_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .pay_i  (pay_d),
    .valid_o(valid_o),
    .pay_o  (pay_q)
  );

  assign {max_val_o, max_idx_o, min_val_o, min_idx_o} = pay_q;
endmodule

// File: rtl/quad_extreme_finder_chk.sv
module quad_extreme_finder_chk #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned N_IN    = 4,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned IDX_W  = $clog2(N_IN)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   valid_i,
  input logic [N_IN*DATA_W-1:0] opd_i,
  input logic [DATA_W-1:0]      max_val_o,
  input logic [IDX_W-1:0]       max_idx_o,
  input logic [DATA_W-1:0]      min_val_o,
  input logic [IDX_W-1:0]       min_idx_o,
  input logic                   valid_o
);
  logic [N_IN*DATA_W-1:0] ref_opd;

  if (REG_OUT) begin : g_ref_reg
    logic [N_IN*DATA_W-1:0] opd_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) opd_q <= '0;
      else if (valid_i) opd_q <= opd_i;
    end
    assign ref_opd = opd_q;

    // R6: valid follows one edge later
    a_r6_valid_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);
    // R7: idle edge drops valid and holds results
    a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> (!valid_o && $stable(max_val_o) && $stable(max_idx_o)
                    && $stable(min_val_o) && $stable(min_idx_o)));
    // R8: reset clears everything
    a_r8_reset_clear: assert property (@(posedge clk_i)
      !rst_ni |=> (!valid_o && max_val_o == '0 && min_val_o == '0
                   && max_idx_o == '0 && min_idx_o == '0));
  end else begin : g_ref_comb
    assign ref_opd = opd_i;
    // R9: valid passes straight through
    a_r9_valid_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o == valid_i);
  end

  // R1 / R3: reported values come from the reported positions
  a_r1_max_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> max_val_o == ref_opd[max_idx_o*DATA_W +: DATA_W]);
  a_r3_min_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> min_val_o == ref_opd[min_idx_o*DATA_W +: DATA_W]);

  for (genvar k = 0; k < N_IN; k++) begin : g_k
    // R1: nothing larger than the max
    a_r1_max_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> max_val_o >= ref_opd[k*DATA_W +: DATA_W]);
    // R3: nothing smaller than the min
    a_r3_min_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> min_val_o <= ref_opd[k*DATA_W +: DATA_W]);
    // R2: lower positions are strictly below the max
    a_r2_max_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && IDX_W'(k) < max_idx_o) |-> ref_opd[k*DATA_W +: DATA_W] < max_val_o);
    // R4: lower positions are strictly above the min
    a_r4_min_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && IDX_W'(k) < min_idx_o) |-> ref_opd[k*DATA_W +: DATA_W] > min_val_o);
  end
endmodule

bind quad_extreme_finder quad_extreme_finder_chk #(
  .DATA_W (DATA_W),
  .N_IN   (N_IN),
  .REG_OUT(REG_OUT)
) i_chk (.*);

// File: tb/test_quad_extreme_finder.sv
module test_quad_extreme_finder;
  localparam int W = 8;
  localparam int N = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [N*W-1:0] opd_i = '0;
  logic [W-1:0]  r_maxv, r_minv, c_maxv, c_minv;
  logic [1:0]    r_maxi, r_mini, c_maxi, c_mini;
  logic          r_vld, c_vld;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  quad_extreme_finder #(.DATA_W(W), .N_IN(N), .REG_OUT(1'b1)) i_quad_extreme_finder (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .opd_i(opd_i),
    .max_val_o(r_maxv), .max_idx_o(r_maxi), .min_val_o(r_minv), .min_idx_o(r_mini),
    .valid_o(r_vld));

  quad_extreme_finder #(.DATA_W(W), .N_IN(N), .REG_OUT(1'b0)) i_comb (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .opd_i(opd_i),
    .max_val_o(c_maxv), .max_idx_o(c_maxi), .min_val_o(c_minv), .min_idx_o(c_mini),
    .valid_o(c_vld));

  typedef struct packed {
    logic [W-1:0] maxv;
    logic [1:0]   maxi;
    logic [W-1:0] minv;
    logic [1:0]   mini;
  } res_t;

  function automatic res_t ref_scan(input logic [N*W-1:0] o);
    res_t r;
    r.maxv = o[W-1:0]; r.maxi = 0;
    r.minv = o[W-1:0]; r.mini = 0;
    for (int k = 1; k < N; k++) begin
      if (o[k*W +: W] > r.maxv) begin r.maxv = o[k*W +: W]; r.maxi = 2'(k); end
      if (o[k*W +: W] < r.minv) begin r.minv = o[k*W +: W]; r.mini = 2'(k); end
    end
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic chk_res(input string tag, input logic [W-1:0] mv, input logic [1:0] mi,
                         input logic [W-1:0] nv, input logic [1:0] ni, input res_t e);
    chk({tag, " R1 max_val"}, int'(mv), int'(e.maxv));
    chk({tag, " R2 max_idx"}, int'(mi), int'(e.maxi));
    chk({tag, " R3 min_val"}, int'(nv), int'(e.minv));
    chk({tag, " R4 min_idx"}, int'(ni), int'(e.mini));
  endtask

  // drive after negedge; comb due at once, registered due at next negedge
  task automatic apply(input logic [N*W-1:0] o, input string tag);
    res_t e;
    e = ref_scan(o);
    opd_i = o;
    valid_i = 1'b1;
    #1;
    chk_res({tag, " R9 comb"}, c_maxv, c_maxi, c_minv, c_mini, e);
    chk("R9 comb valid", int'(c_vld), 1);
    @(negedge clk_i);
    chk_res({tag, " R6 reg"}, r_maxv, r_maxi, r_minv, r_mini, e);
    chk("R6 reg valid", int'(r_vld), 1);
  endtask

  function automatic logic [N*W-1:0] rnd_opd();
    return {8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom)};
  endfunction

  function automatic logic [N*W-1:0] mid_opd();
    logic [N*W-1:0] o;
    for (int k = 0; k < N; k++) o[k*W +: W] = 8'(1 + ($urandom % 254));
    return o;
  endfunction

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [N*W-1:0] o;
    res_t e, prev;
    void'($urandom(32'h5eed_1234));
    opd_i = 32'hA5C3_7F19;
    repeat (3) @(negedge clk_i);
    chk("R8 reset valid", int'(r_vld), 0);
    chk("R8 reset max_val", int'(r_maxv), 0);
    chk("R8 reset max_idx", int'(r_maxi), 0);
    chk("R8 reset min_val", int'(r_minv), 0);
    chk("R8 reset min_idx", int'(r_mini), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // directed examples: operand 0 in low byte
    apply({8'd255, 8'd0, 8'd51, 8'd34}, "ex_a");
    chk("R2 ex_a max_idx=3", int'(r_maxi), 3);
    chk("R4 ex_a min_idx=2", int'(r_mini), 2);
    apply({8'd255, 8'd255, 8'd51, 8'd34}, "ex_b");
    chk("R2 ex_b tie max_idx=2", int'(r_maxi), 2);

    // all equal
    for (int v = 0; v < 4; v++) begin
      logic [W-1:0] c;
      c = (v == 0) ? 8'd0 : (v == 1) ? 8'd255 : 8'($urandom);
      apply({c, c, c, c}, "eq");
      chk("R5 eq max_idx", int'(r_maxi), 0);
      chk("R5 eq min_idx", int'(r_mini), 0);
      chk("R5 eq max_val", int'(r_maxv), int'(c));
      chk("R5 eq min_val", int'(c_minv), int'(c));
    end

    // ties at every pair of positions
    for (int a = 0; a < N; a++) begin
      for (int b = a + 1; b < N; b++) begin
        o = mid_opd();
        o[a*W +: W] = 8'd255; o[b*W +: W] = 8'd255;
        apply(o, "tie_hi");
        chk("R2 tie pair max_idx", int'(r_maxi), a);
        o = mid_opd();
        o[a*W +: W] = 8'd0; o[b*W +: W] = 8'd0;
        apply(o, "tie_lo");
        chk("R4 tie pair min_idx", int'(r_mini), a);
        o = mid_opd();
        o[a*W +: W] = 8'd200; o[b*W +: W] = 8'd200;
        for (int k = 0; k < N; k++) if (k != a && k != b) o[k*W +: W] = 8'd100;
        apply(o, "tie_mid");
        chk("R2 tie mid max_idx", int'(r_maxi), a);
      end
    end

    // random with idle gaps
    for (int n = 0; n < 300; n++) begin
      o = (n % 5 == 0) ? {4{8'($urandom)}} : rnd_opd();
      apply(o, "rnd");
      if (n % 7 == 3) begin
        prev = ref_scan(o);
        opd_i = rnd_opd();
        valid_i = 1'b0;
        #1;
        chk("R9 comb idle valid", int'(c_vld), 0);
        e = ref_scan(opd_i);
        chk("R9 comb idle max_val", int'(c_maxv), int'(e.maxv));
        @(negedge clk_i);
        chk("R7 idle valid", int'(r_vld), 0);
        chk_res("R7 hold", r_maxv, r_maxi, r_minv, r_mini, prev);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule